// File: doc/BRIEF.md
# Serial Sampling Converter Frame and Power Controller

This block is the digital front of a small serial sampling converter. A host frames each transfer with an active-low select line and supplies a serial clock. The block counts falling serial-clock edges inside each frame and shifts a 16-bit word out on a three-state data line, most significant bit first. The word is four zero bits followed by a 12-bit sample. The sample comes from a parallel stub input and is captured when the frame opens.

The point in the frame at which the host raises the select line decides what happens next. Raising it very early leaves the power state alone. Raising it in the early-middle window powers the analog section down. Raising it later only cuts the word short. Holding it low through all sixteen edges completes the read. A power-up output drives the analog section, and a status output records how the last frame ended.

All inputs are asynchronous to the system clock, so they are synchronized first. A cycle counter in the system clock domain flags any frame that opens before a minimum quiet interval has passed since the previous frame ended.

Top module: `adc_serial_ctrl`

## Requirements
- R1: After reset the outputs are as follows: `pwr_up`=1, `sdata_oe`=0, `sdata`=0, `frame_status`=0 (no frame yet) and `quiet_viol`=0.
- R2: A falling edge on `cs_n` opens a frame and sets `sdata_oe`=1. It presents bit 15 of the word {4'b0000, `sample_in`}, and each later falling edge of `sclk` presents the next lower bit.
- R3: On the sixteenth falling `sclk` edge of a frame, `sdata_oe` returns to 0, `frame_status` becomes 4 (complete) and `pwr_up` is unchanged.
- R4: If `cs_n` rises after fewer than two falling `sclk` edges, `frame_status` becomes 1 (no mode change), `sdata_oe` goes to 0 and `pwr_up` keeps its value.
- R5: If `cs_n` rises after two to nine falling `sclk` edges, `pwr_up` goes to 0, `frame_status` becomes 2 (power-down) and `sdata_oe` goes to 0.
- R6: If `cs_n` rises after ten to fifteen falling `sclk` edges, `frame_status` becomes 3 (aborted), `sdata_oe` goes to 0 and `pwr_up` stays 1.
- R7: Once powered down, `pwr_up` stays 0 whatever `sclk` does while `cs_n` is high. The next falling edge of `cs_n` sets it back to 1.
- R8: After a complete frame, further `sclk` edges with `cs_n` still low, and the later rise of `cs_n`, change neither `sdata_oe` nor `frame_status`. No new frame starts until `cs_n` rises and falls again.
- R9: When a frame opens fewer than QUIET_CYC system clocks after the previous frame ended, `quiet_viol` is 1 for that frame. Otherwise it is 0.
- R10: The sample is captured at the opening of the frame, so later changes on `sample_in` do not alter the word being shifted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low frame select, asynchronous |
| sclk | input | 1 | Serial clock, asynchronous, idles high |
| sample_in | input | 12 | Parallel sample from the converter stub |
| sdata | output | 1 | Serial data bit |
| sdata_oe | output | 1 | Output enable for the three-state data pad |
| pwr_up | output | 1 | 1 powers the analog section, 0 powers it down |
| frame_status | output | 3 | Outcome of the last frame: 0 none, 1 no change, 2 power-down, 3 aborted, 4 complete |
| quiet_viol | output | 1 | Current frame opened inside the quiet interval |

## Verification
The assertions assume two things about the inputs. First, `cs_n` and `sclk` never change in the same system clock cycle. Second, each level is held for several clock cycles, so the synchronizers see every edge as a single one-cycle event. The stimulus keeps every input level for six clock cycles and moves only one of the two lines at a time. Each frame's outcome is checked after the synchronizer delay has passed.

// File: rtl/adc_ifc_pkg.sv
package adc_ifc_pkg;
  typedef enum logic [2:0] {
    FS_NONE     = 3'd0,
    FS_NOCHANGE = 3'd1,
    FS_PDOWN    = 3'd2,
    FS_ABORT    = 3'd3,
    FS_COMPLETE = 3'd4
  } frame_status_e;
endpackage

// File: rtl/edge_sync.sv
module edge_sync #(
  parameter int STAGES = 2,
  parameter logic INIT = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic level,
  output logic fall,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              prev;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= INIT;
        else if (g == 0) chain[g] <= din;
        else chain[g] <= chain[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev <= INIT;
    else     prev <= chain[STAGES-1];
  end

  assign level = chain[STAGES-1];
  assign fall  = prev & ~chain[STAGES-1];
  assign rise  = ~prev & chain[STAGES-1];
endmodule

// File: rtl/frame_ctrl.sv
module frame_ctrl
  import adc_ifc_pkg::*;
#(
  parameter int WORD_BITS = 16,
  parameter int PD_FIRST  = 2,
  parameter int PD_LAST   = 9,
  localparam int CNT_W    = $clog2(WORD_BITS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel_low,
  input  logic             sel_fall,
  input  logic             sel_rise,
  input  logic             sck_fall,
  output logic [CNT_W-1:0] edge_cnt,
  output logic             shift_en,
  output logic             frame_end,
  output logic             data_oe,
  output logic             power_on,
  output frame_status_e    status
);
  logic active;
  logic last_edge;

  assign last_edge = sck_fall && (edge_cnt == CNT_W'(WORD_BITS - 1));
  assign frame_end = active && !sel_fall && (sel_rise || last_edge);
  assign shift_en  = active && sck_fall && !last_edge;

  always_ff @(posedge clk) begin
    if (rst) begin
      edge_cnt <= '0;
    end else if (sel_fall) begin
      edge_cnt <= '0;
    end else if (sel_low && sck_fall && edge_cnt != CNT_W'(WORD_BITS)) begin
      edge_cnt <= edge_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active   <= 1'b0;
      data_oe  <= 1'b0;
      power_on <= 1'b1;
      status   <= FS_NONE;
    end else if (sel_fall) begin
      active   <= 1'b1;
      data_oe  <= 1'b1;
      power_on <= 1'b1;
    end else if (frame_end) begin
      active  <= 1'b0;
      data_oe <= 1'b0;
      if (last_edge) begin
        status <= FS_COMPLETE;
      end else if (edge_cnt < CNT_W'(PD_FIRST)) begin
        status <= FS_NOCHANGE;
      end else if (edge_cnt <= CNT_W'(PD_LAST)) begin
        status   <= FS_PDOWN;
        power_on <= 1'b0;
      end else begin
        status <= FS_ABORT;
      end
    end
  end
endmodule

// File: rtl/word_shifter.sv
module word_shifter #(
  parameter int WORD_BITS   = 16,
  parameter int SAMPLE_BITS = 12,
  localparam int PAD        = WORD_BITS - SAMPLE_BITS
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   load,
  input  logic                   shift,
  input  logic                   clear,
  input  logic [SAMPLE_BITS-1:0] sample,
  output logic                   bit_out
);
  logic [WORD_BITS-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst || clear) sh <= '0;
    else if (load)    sh <= {{PAD{1'b0}}, sample};
    else if (shift)   sh <= {sh[WORD_BITS-2:0], 1'b0};
  end

  assign bit_out = sh[WORD_BITS-1];
endmodule

// File: rtl/quiet_timer.sv
module quiet_timer #(
  parameter int QUIET_CYC = 20,
  localparam int T_W      = $clog2(QUIET_CYC + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic frame_end,
  input  logic frame_start,
  output logic viol
);
  logic [T_W-1:0] since_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      since_end <= T_W'(QUIET_CYC);
    end else if (frame_end) begin
      since_end <= '0;
    end else if (since_end != T_W'(QUIET_CYC)) begin
      since_end <= since_end + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)              viol <= 1'b0;
    else if (frame_start) viol <= (since_end != T_W'(QUIET_CYC));
  end
endmodule

// File: rtl/adc_serial_ctrl.sv
module adc_serial_ctrl
  import adc_ifc_pkg::*;
#(
  parameter int WORD_BITS   = 16,
  parameter int SAMPLE_BITS = 12,
  parameter int PD_FIRST    = 2,
  parameter int PD_LAST     = 9,
  parameter int QUIET_CYC   = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cs_n,
  input  logic                   sclk,
  input  logic [SAMPLE_BITS-1:0] sample_in,
  output logic                   sdata,
  output logic                   sdata_oe,
  output logic                   pwr_up,
  output logic [2:0]             frame_status,
  output logic                   quiet_viol
);
  localparam int CNT_W = $clog2(WORD_BITS + 1);

  logic             cs_lvl, cs_fall, cs_rise;
  logic             sck_lvl, sck_fall, sck_rise;
  logic [CNT_W-1:0] edge_cnt;
  logic             shift_en, frame_end;
  frame_status_e    status;

  edge_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_cs_sync (
    .clk(clk), .rst(rst), .din(cs_n),
    .level(cs_lvl), .fall(cs_fall), .rise(cs_rise)
  );

  edge_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_sck_sync (
    .clk(clk), .rst(rst), .din(sclk),
    .level(sck_lvl), .fall(sck_fall), .rise(sck_rise)
  );

  frame_ctrl #(.WORD_BITS(WORD_BITS), .PD_FIRST(PD_FIRST), .PD_LAST(PD_LAST)) u_ctrl (
    .clk(clk), .rst(rst),
    .sel_low(~cs_lvl), .sel_fall(cs_fall), .sel_rise(cs_rise), .sck_fall(sck_fall),
    .edge_cnt(edge_cnt), .shift_en(shift_en), .frame_end(frame_end),
    .data_oe(sdata_oe), .power_on(pwr_up), .status(status)
  );

  word_shifter #(.WORD_BITS(WORD_BITS), .SAMPLE_BITS(SAMPLE_BITS)) u_shift (
    .clk(clk), .rst(rst), .load(cs_fall), .shift(shift_en), .clear(frame_end),
    .sample(sample_in), .bit_out(sdata)
  );

  quiet_timer #(.QUIET_CYC(QUIET_CYC)) u_quiet (
    .clk(clk), .rst(rst), .frame_end(frame_end), .frame_start(cs_fall),
    .viol(quiet_viol)
  );

  assign frame_status = status;

  logic unused_ok;
  assign unused_ok = sck_lvl ^ sck_rise;
endmodule

// File: rtl/adc_serial_ctrl_chk.sv
module adc_serial_ctrl_chk #(
  parameter int CNT_W     = 5,
  parameter int WORD_BITS = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             cs_fall,
  input logic             cs_rise,
  input logic             sck_fall,
  input logic [CNT_W-1:0] edge_cnt,
  input logic             pwr_up,
  input logic             sdata_oe,
  input logic [2:0]       frame_status
);
  // R3
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    edge_cnt <= CNT_W'(WORD_BITS));

  // R2
  cnt_restart_chk: assert property (@(posedge clk) disable iff (rst)
    cs_fall |=> edge_cnt == '0);

  // R2
  oe_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sdata_oe) |-> $past(cs_fall));

  // R2
  oe_powered_chk: assert property (@(posedge clk) disable iff (rst)
    sdata_oe |-> pwr_up);

  // R6
  oe_end_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(sdata_oe) |-> $past(cs_rise || sck_fall));

  // R5
  pdown_status_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(pwr_up) |-> frame_status == 3'd2);

  // R7
  wake_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pwr_up) |-> $past(cs_fall));
endmodule

bind adc_serial_ctrl adc_serial_ctrl_chk #(.CNT_W(CNT_W), .WORD_BITS(WORD_BITS)) u_chk (
  .clk(clk), .rst(rst), .cs_fall(cs_fall), .cs_rise(cs_rise), .sck_fall(sck_fall),
  .edge_cnt(edge_cnt), .pwr_up(pwr_up), .sdata_oe(sdata_oe), .frame_status(frame_status)
);

// File: tb/test_adc_serial_ctrl.sv
module test_adc_serial_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cs_n = 1'b1;
  logic        sclk = 1'b1;
  logic [11:0] sample_in = '0;
  logic        sdata, sdata_oe, pwr_up, quiet_viol;
  logic [2:0]  frame_status;

  int checks = 0;
  int failures = 0;
  localparam int HOLD = 6;

  always #2.5 clk = ~clk;

  adc_serial_ctrl i_adc_serial_ctrl (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .sample_in(sample_in),
    .sdata(sdata), .sdata_oe(sdata_oe), .pwr_up(pwr_up),
    .frame_status(frame_status), .quiet_viol(quiet_viol)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Opens a frame after `gap` cycles with cs_n high, gives `nfalls` sclk falls, raises cs_n.
  task automatic frame(input logic [11:0] smp, input int nfalls, input int gap,
                       input bit exp_viol, input int exp_st, input bit exp_pwr);
    logic [15:0] word;
    word = {4'b0000, smp};
    idle(gap);
    sample_in = smp;
    cs_n = 1'b0;
    idle(HOLD);
    sample_in = ~smp; // R10: later changes must not alter the word
    check("R9 quiet flag", quiet_viol, exp_viol);
    check("R7 powered on frame start", pwr_up, 1);
    check("R2 oe at start", sdata_oe, 1);
    check("R2 msb", sdata, word[15]);
    for (int i = 1; i <= nfalls; i++) begin
      sclk = 1'b0;
      idle(HOLD);
      if (i < 16) begin
        check("R10 word bit", sdata, word[15-i]);
        check("R2 oe mid frame", sdata_oe, 1);
      end else begin
        check("R3 oe after 16th", sdata_oe, 0);
        check("R3 status complete", frame_status, 4);
        check("R3 power kept", pwr_up, 1);
      end
      sclk = 1'b1;
      idle(HOLD);
    end
    if (nfalls >= 16) begin
      for (int k = 0; k < 2; k++) begin
        sclk = 1'b0; idle(HOLD); sclk = 1'b1; idle(HOLD);
      end
      check("R8 oe stays low", sdata_oe, 0);
      check("R8 status held", frame_status, 4);
    end
    cs_n = 1'b1;
    idle(HOLD);
    check("R4 R5 R6 R8 status after rise", frame_status, exp_st);
    check("R4 R5 R6 power after rise", pwr_up, exp_pwr);
    check("R5 R6 oe after rise", sdata_oe, 0);
  endtask

  task automatic test_reset();
    check("R1 pwr_up", pwr_up, 1);
    check("R1 oe", sdata_oe, 0);
    check("R1 sdata", sdata, 0);
    check("R1 status", frame_status, 0);
    check("R1 quiet", quiet_viol, 0);
  endtask

  task automatic test_powerdown_hold();
    for (int k = 0; k < 4; k++) begin
      sclk = 1'b0; idle(HOLD); sclk = 1'b1; idle(HOLD);
    end
    check("R7 stays down", pwr_up, 0);
    check("R7 oe low while down", sdata_oe, 0);
  endtask

  initial begin
    idle(5);
    rst = 1'b0;
    idle(3);
    test_reset();
    frame(12'hA5C, 16, 40, 0, 4, 1);   // R3 R8 R10
    frame(12'h3F1, 1, 40, 0, 1, 1);    // R4
    frame(12'h0F0, 2, 40, 0, 2, 0);    // R5 lower bound
    test_powerdown_hold();             // R7
    frame(12'hFFF, 9, 40, 0, 2, 0);    // R5 upper bound, wakes then sleeps
    frame(12'h123, 0, 40, 0, 1, 1);    // R4 from power-down: wake kept
    frame(12'h5A5, 10, 40, 0, 3, 1);   // R6 lower bound
    frame(12'h9C3, 15, 4, 1, 3, 1);    // R6 upper bound, R9 short gap
    frame(12'h777, 16, 40, 0, 4, 1);   // R9 long gap, R3 again
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule